// File: doc/BRIEF.md
# Four-Way Write-Through Line Cache

This block is a unified cache for instructions and data. It sits between a 32-bit processor-side request port and a 32-bit memory-side port. The default size is 8 KB, split into four ways of 16-byte lines. Each line holds four 32-bit words, which gives 128 sets. Every set keeps a valid bit and a tag for each way, plus a three-bit tree that records which way was used least recently.

A read that hits returns its word and acknowledges in the same cycle it is presented. A read that misses first picks a way. A way that is not yet valid is always preferred, and the binary tree chooses a victim only when the set is full. The block then fetches the whole line as a four-word burst and serves the read from the cache on the following cycle.

Stores always go through to memory, and the store is acknowledged in the cycle memory accepts it. A store that hits also updates the cached word. A store that misses leaves the cache unchanged. A flush input marks every line invalid in one cycle. The caller holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the cycle it raises the request until the cycle `cpu_ack` is high.

Top module: `wt_sa_cache`

## Requirements
- R1: After reset, and after a cycle in which `flush` is high while the block is idle, every line is invalid, so the next read of any address misses. When `flush` is high in the same idle cycle as a request, the request is neither acknowledged nor started in that cycle.
- R2: A read that hits gives `cpu_ack`=1 and the cached word on `cpu_rdata` in the same cycle the request is presented, with `mem_req`=0.
- R3: A read miss issues four memory reads with `mem_we`=0 and `mem_burst`=1. Their addresses are line base +0, +4, +8 and +12, in that order. After the fourth accepted beat, the read is acknowledged with the word that memory returned.
- R4: Every store issues exactly one memory write. The write carries the word-aligned store address (bits 1:0 zero), `cpu_wdata` and `mem_burst`=0. `cpu_ack` rises in the cycle `mem_ready` accepts it.
- R5: A store that hits also replaces the cached word, so a later read hit returns the stored value.
- R6: A store that misses allocates no line, so a later read of that address misses and fills from memory.
- R7: On a read miss, the lowest-numbered way that is not valid in the set receives the line.
- R8: When all four ways are valid, the victim is chosen from the tree bits B0, B1 and B2. B0=0 selects way 0 (B1=0) or way 1 (B1=1). B0=1 selects way 2 (B2=0) or way 3 (B2=1). All tree bits are zero after reset.
- R9: A read hit, a store hit or a completed fill of way w sets B0 to point at the other pair: B0=1 for ways 0 and 1, and B0=0 for ways 2 and 3. It sets B1 (for ways 0 and 1) or B2 (for ways 2 and 3) to point at the other way of the pair, and leaves the third bit unchanged.
- R10: The address splits into tag bits 31:11, set bits 10:4 and word bits 3:2. Bits 1:0 are ignored on reads, and an address matches at most one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines (taken when idle) |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on reads |
| cpu_ack | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_burst | output | 1 | Access is one beat of a line fill |
| mem_addr | output | 32 | Word-aligned memory address of the current beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current beat this cycle |

## Verification
The bench fills one set past its four ways and then keeps hitting and missing in it. Its behavioural replacement tree predicts every later hit or miss. A design that fills the wrong free way, reads a tree bit backwards or moves the wrong bit on a touch would miss where a hit is due, and would show up as unexpected burst traffic. A store that hits is followed by a read of the same word: stale cache data there means the cached copy was not updated. A read that follows a store miss must fetch from memory, which exposes any allocation on write. A flush raised together with a hitting read catches a design that serves the request before the invalidation. Memory latency varies between zero and two cycles, so a burst that drops or repeats a beat under stalls shows up as a wrong beat address or a wrong beat count.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_FILL  = 2'd1,
      CS_STORE = 2'd2
   } ctl_state_e;

   // tree bit 0 picks the pair, bit 1 the way in pair {0,1}, bit 2 the way in pair {2,3}
   function automatic logic [2:0] tree_touch(input logic [2:0] cur, input logic [1:0] way);
      logic [2:0] nxt;
      nxt    = cur;
      nxt[0] = ~way[1];
      if (way[1]) nxt[2] = ~way[0];
      else        nxt[1] = ~way[0];
      return nxt;
   endfunction

   function automatic logic [1:0] tree_pick(input logic [2:0] cur);
      return cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
   endfunction

endpackage

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 128,
   parameter int TAG_W = 21
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_all,
   input  logic [$clog2(SETS)-1:0]  look_set,
   input  logic [TAG_W-1:0]         look_tag,
   output logic [WAYS-1:0]          hit_vec,
   output logic [WAYS-1:0]          vld_row,
   input  logic                     wr_en,
   input  logic [$clog2(WAYS)-1:0]  wr_way,
   input  logic [$clog2(SETS)-1:0]  wr_set,
   input  logic [TAG_W-1:0]         wr_tag
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);

   if ((1 << SET_W) != SETS) begin : g_bad_sets
      $error("wtc_tag_store: SETS must be a power of two");
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic             sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (sel) tag_q[wr_set] <= wr_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         vld_q <= '0;
         else if (clear_all) vld_q <= '0;
         else if (sel)       vld_q[wr_set] <= 1'b1;
      end

      assign vld_row[w] = vld_q[look_set];
      assign hit_vec[w] = vld_q[look_set] && (tag_q[look_set] == look_tag);

      // R1: a flush leaves no valid line behind
      p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
         clear_all |=> (vld_q == '0));
   end

endmodule

// File: rtl/wtc_data_store.sv
`timescale 1ns/1ps
module wtc_data_store #(
   parameter int WAYS   = 4,
   parameter int SETS   = 128,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic [$clog2(SETS)-1:0]   rd_set,
   input  logic [$clog2(WORDS)-1:0]  rd_word,
   input  logic [$clog2(WAYS)-1:0]   rd_way,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      wr_en,
   input  logic [$clog2(WAYS)-1:0]   wr_way,
   input  logic [$clog2(SETS)-1:0]   wr_set,
   input  logic [$clog2(WORDS)-1:0]  wr_word,
   input  logic [DATA_W-1:0]         wr_data
);
   localparam int SET_W  = $clog2(SETS);
   localparam int WORD_W = $clog2(WORDS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int DEPTH  = SETS * WORDS;
   localparam int IDX_W  = SET_W + WORD_W;

   if ((1 << WORD_W) != WORDS) begin : g_bad_words
      $error("wtc_data_store: WORDS must be a power of two");
   end

   logic [DATA_W-1:0] rd_lane [WAYS];
   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  wr_idx;

   assign rd_idx = {rd_set, rd_word};
   assign wr_idx = {wr_set, wr_word};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [DATA_W-1:0] mem_q [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == WAY_W'(w))) mem_q[wr_idx] <= wr_data;
      end

      assign rd_lane[w] = mem_q[rd_idx];
   end

   assign rd_data = rd_lane[rd_way];

endmodule

// File: rtl/wtc_plru.sv
`timescale 1ns/1ps
module wtc_plru
   import wtc_pkg::*;
#(
   parameter int WAYS = 4,
   parameter int SETS = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SETS)-1:0]  look_set,
   input  logic [WAYS-1:0]          vld_row,
   input  logic                     touch_en,
   input  logic [$clog2(SETS)-1:0]  touch_set,
   input  logic [$clog2(WAYS)-1:0]  touch_way,
   output logic [$clog2(WAYS)-1:0]  victim
);
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS != 4) begin : g_bad_ways
      $error("wtc_plru: the three-bit tree serves exactly four ways");
   end

   logic [2:0] lru_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
      end else if (touch_en) begin
         lru_q[touch_set] <= tree_touch(lru_q[touch_set], touch_way);
      end
   end

   always_comb begin
      victim = WAY_W'(tree_pick(lru_q[look_set]));
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_row[w]) victim = WAY_W'(w);
      end
   end

   // R7: a free way is always chosen before a valid one
   p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(&vld_row) |-> !vld_row[victim]);

   // R9: right after a touch the tree never names the touched way
   p_touch_away_r9: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (tree_pick(lru_q[$past(touch_set)]) != 2'($past(touch_way))));

endmodule

// File: rtl/wt_sa_cache.sv
`timescale 1ns/1ps
module wt_sa_cache
   import wtc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CACHE_BYTES = 8192,
   parameter int LINE_BYTES  = 16,
   parameter int WAYS        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_burst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int BYTES_W = DATA_W / 8;
   localparam int BYTE_W  = $clog2(BYTES_W);
   localparam int WORDS   = LINE_BYTES / BYTES_W;
   localparam int WORD_W  = $clog2(WORDS);
   localparam int OFF_W   = BYTE_W + WORD_W;
   localparam int SETS    = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int SET_W   = $clog2(SETS);
   localparam int TAG_W   = ADDR_W - SET_W - OFF_W;
   localparam int WAY_W   = $clog2(WAYS);
   localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

   if (DATA_W % 8 != 0 || (1 << BYTE_W) != BYTES_W) begin : g_bad_data
      $error("wt_sa_cache: DATA_W must be a power-of-two number of bytes");
   end
   if ((1 << WORD_W) != WORDS || WORDS < 2) begin : g_bad_line
      $error("wt_sa_cache: a line must hold a power-of-two count of words, at least two");
   end
   if ((1 << SET_W) != SETS || TAG_W < 1) begin : g_bad_size
      $error("wt_sa_cache: capacity must give a power-of-two set count and a tag");
   end
   if (WAYS != 4) begin : g_bad_ways
      $error("wt_sa_cache: four ways are required by the replacement tree");
   end

   // address fields
   logic [TAG_W-1:0]  look_tag;
   logic [SET_W-1:0]  look_set;
   logic [WORD_W-1:0] look_word;
   logic [BYTE_W-1:0] unused_byte_bits;

   assign look_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
   assign look_set         = cpu_addr[OFF_W +: SET_W];
   assign look_word        = cpu_addr[BYTE_W +: WORD_W];
   assign unused_byte_bits = cpu_addr[BYTE_W-1:0];

   // control state
   ctl_state_e        state_q, state_d;
   logic [WORD_W-1:0] beat_q, beat_d;
   logic [WAY_W-1:0]  victim_q, victim_d;

   // lookup results
   logic [WAYS-1:0]  hit_vec;
   logic [WAYS-1:0]  vld_row;
   logic             hit;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] pick_way;

   // update strobes
   logic              clear_all;
   logic              dw_en, tw_en, touch_en;
   logic [WAY_W-1:0]  dw_way;
   logic [WORD_W-1:0] dw_word;
   logic [DATA_W-1:0] dw_data;
   logic              idle_take;

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign idle_take = (state_q == CS_IDLE) && cpu_req && !flush;
   assign clear_all = (state_q == CS_IDLE) && flush;

   always_comb begin
      state_d  = state_q;
      beat_d   = beat_q;
      victim_d = victim_q;
      dw_en    = 1'b0;
      tw_en    = 1'b0;
      touch_en = 1'b0;
      unique case (state_q)
         CS_IDLE: begin
            if (idle_take) begin
               if (cpu_we) begin
                  state_d = CS_STORE;
               end else if (hit) begin
                  touch_en = 1'b1;
               end else begin
                  state_d  = CS_FILL;
                  beat_d   = '0;
                  victim_d = pick_way;
               end
            end
         end
         CS_FILL: begin
            if (mem_ready) begin
               dw_en  = 1'b1;
               beat_d = beat_q + 1'b1;
               if (beat_q == LAST_BEAT) begin
                  tw_en    = 1'b1;
                  touch_en = 1'b1;
                  state_d  = CS_IDLE;
               end
            end
         end
         CS_STORE: begin
            if (mem_ready) begin
               dw_en    = hit;
               touch_en = hit;
               state_d  = CS_IDLE;
            end
         end
         default: state_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CS_IDLE;
         beat_q   <= '0;
         victim_q <= '0;
      end else begin
         state_q  <= state_d;
         beat_q   <= beat_d;
         victim_q <= victim_d;
      end
   end

   // write-side selects: a fill writes the chosen way, a store hit its own way
   assign dw_way  = (state_q == CS_FILL) ? victim_q  : hit_way;
   assign dw_word = (state_q == CS_FILL) ? beat_q    : look_word;
   assign dw_data = (state_q == CS_FILL) ? mem_rdata : cpu_wdata;

   // processor side
   assign cpu_ack = (idle_take && !cpu_we && hit) ||
                    ((state_q == CS_STORE) && mem_ready);

   // memory side
   assign mem_req   = (state_q != CS_IDLE);
   assign mem_we    = (state_q == CS_STORE);
   assign mem_burst = (state_q == CS_FILL);
   assign mem_wdata = cpu_wdata;

   always_comb begin
      if (state_q == CS_FILL)
         mem_addr = {cpu_addr[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
      else
         mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
   end

   wtc_tag_store #(
      .WAYS  (WAYS),
      .SETS  (SETS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (clear_all),
      .look_set  (look_set),
      .look_tag  (look_tag),
      .hit_vec   (hit_vec),
      .vld_row   (vld_row),
      .wr_en     (tw_en),
      .wr_way    (victim_q),
      .wr_set    (look_set),
      .wr_tag    (look_tag)
   );

   wtc_data_store #(
      .WAYS   (WAYS),
      .SETS   (SETS),
      .WORDS  (WORDS),
      .DATA_W (DATA_W)
   ) u_data (
      .clk     (clk),
      .rd_set  (look_set),
      .rd_word (look_word),
      .rd_way  (hit_way),
      .rd_data (cpu_rdata),
      .wr_en   (dw_en),
      .wr_way  (dw_way),
      .wr_set  (look_set),
      .wr_word (dw_word),
      .wr_data (dw_data)
   );

   wtc_plru #(
      .WAYS (WAYS),
      .SETS (SETS)
   ) u_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_set  (look_set),
      .vld_row   (vld_row),
      .touch_en  (touch_en),
      .touch_set (look_set),
      .touch_way ((state_q == CS_FILL) ? victim_q : hit_way),
      .victim    (pick_way)
   );

   // R10: an address can match at most one way
   p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R2: a read served from the cache causes no memory traffic
   p_read_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !cpu_we) |-> !mem_req);

   // R4: a store is acknowledged only as memory takes it
   p_store_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_we) |-> (mem_we && mem_ready));

   // R3: the last accepted beat installs the line for the waiting read
   p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == CS_FILL) && mem_ready && (beat_q == LAST_BEAT)) |=> hit);

   // R3: no acknowledge while a line is still arriving
   p_no_ack_in_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_FILL) |-> !cpu_ack);

endmodule

// File: tb/sim_wt_sa_cache.sv
`timescale 1ns/1ps
module sim_wt_sa_cache;

   logic        clk;
   logic        rst_n;
   logic        flush;
   logic        cpu_req;
   logic        cpu_we;
   logic [31:0] cpu_addr;
   logic [31:0] cpu_wdata;
   logic [31:0] cpu_rdata;
   logic        cpu_ack;
   logic        mem_req;
   logic        mem_we;
   logic        mem_burst;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ready;

   wt_sa_cache u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .cpu_ack   (cpu_ack),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_burst (mem_burst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready)
   );

   // 50 MHz
   initial clk = 1'b0;
   always #10 clk = ~clk;

   int nerr = 0;
   int nchk = 0;
   int lat  = 0;
   int nbeats = 0;
   bit done = 0;

   // behavioural memory and cache model
   logic [31:0] mem_img [logic [31:0]];
   bit          mv [128][4];
   bit [20:0]   mt [128][4];
   bit [2:0]    ml [128];

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      if (mem_img.exists(a)) return mem_img[a];
      return a ^ 32'hC3A5_0F96 ^ {a[15:0], a[31:16]};
   endfunction

   function automatic bit m_lookup(input logic [31:0] a, output int way);
      int s = int'(a[10:4]);
      way = 0;
      for (int w = 0; w < 4; w++) begin
         if (mv[s][w] && mt[s][w] == a[31:11]) begin
            way = w;
            return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   function automatic int m_victim(input int s);
      for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
      if (ml[s][0]) return ml[s][2] ? 3 : 2;
      return ml[s][1] ? 1 : 0;
   endfunction

   function automatic void m_touch(input int s, input int w);
      ml[s][0] = (w < 2);
      if (w < 2) ml[s][1] = (w == 0);
      else       ml[s][2] = (w == 2);
   endfunction

   function automatic void m_flush();
      for (int s = 0; s < 128; s++)
         for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   // memory responder: acts at the falling edge, one beat at a time
   initial begin
      int wait_cnt;
      wait_cnt  = 0;
      mem_ready = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
            nbeats++;
            wait_cnt = 0;
         end else if (mem_req === 1'b1) begin
            if (wait_cnt >= lat) begin
               mem_ready = 1'b1;
               if (mem_we) mem_img[mem_addr] = mem_wdata;
               else        mem_rdata = mem_rd(mem_addr);
            end else begin
               wait_cnt++;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   task automatic do_rd(input logic [31:0] a, input bit with_flush, input string rq);
      int  s;
      int  way;
      bit  hit;
      bit  acked;
      logic [31:0] exp;
      s = int'(a[10:4]);
      acked = 0;
      @(negedge clk); #1;
      cpu_req  = 1'b1;
      cpu_we   = 1'b0;
      cpu_addr = a;
      nbeats   = 0;
      if (with_flush) begin
         flush = 1'b1;
         #4;
         chk(cpu_ack === 1'b0 && mem_req === 1'b0, "R1", "flush blocks request",
             {30'd0, cpu_ack, mem_req}, 32'd0);
         @(posedge clk);
         m_flush();
         @(negedge clk); #1;
         flush = 1'b0;
      end
      hit = m_lookup(a, way);
      for (int c = 0; c < 60; c++) begin
         #4;
         exp = mem_rd({a[31:2], 2'b00});
         if (hit) begin
            chk(cpu_ack === 1'b1 && mem_req === 1'b0, rq, "read hit same cycle",
                {30'd0, cpu_ack, mem_req}, 32'd2);
            chk(cpu_rdata === exp, rq, "read hit data", cpu_rdata, exp);
            acked = 1;
            break;
         end
         if (c == 0) begin
            chk(cpu_ack === 1'b0 && mem_req === 1'b0, "R3", "miss idle cycle",
                {30'd0, cpu_ack, mem_req}, 32'd0);
         end else if (cpu_ack === 1'b1) begin
            chk(nbeats == 4, "R3", "fill beat count", 32'(nbeats), 32'd4);
            chk(cpu_rdata === exp, "R3", "miss data", cpu_rdata, exp);
            acked = 1;
            break;
         end else if (mem_req === 1'b1) begin
            chk(mem_we === 1'b0 && mem_burst === 1'b1, "R3", "fill beat kind",
                {30'd0, mem_we, mem_burst}, 32'd1);
            chk(mem_addr === {a[31:4], 2'(nbeats), 2'b00}, "R3", "fill beat address",
                mem_addr, {a[31:4], 2'(nbeats), 2'b00});
         end
         @(negedge clk); #1;
      end
      if (!acked) chk(1'b0, rq, "read never acknowledged", 32'd0, 32'd1);
      if (!hit) begin
         way = m_victim(s);
         mv[s][way] = 1'b1;
         mt[s][way] = a[31:11];
         m_touch(s, way);
      end
      m_touch(s, way);
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic do_wr(input logic [31:0] a, input logic [31:0] d, input string rq);
      int  way;
      bit  hit;
      bit  acked;
      acked = 0;
      hit = m_lookup(a, way);
      @(negedge clk); #1;
      cpu_req   = 1'b1;
      cpu_we    = 1'b1;
      cpu_addr  = a;
      cpu_wdata = d;
      nbeats    = 0;
      for (int c = 0; c < 60; c++) begin
         #4;
         if (c == 0) begin
            chk(cpu_ack === 1'b0 && mem_req === 1'b0, "R4", "store idle cycle",
                {30'd0, cpu_ack, mem_req}, 32'd0);
         end else if (cpu_ack === 1'b1) begin
            chk(mem_we === 1'b1 && mem_ready === 1'b1, "R4", "store ack with accept",
                {30'd0, mem_we, mem_ready}, 32'd3);
            chk(mem_rd({a[31:2], 2'b00}) === d, rq, "memory holds store",
                mem_rd({a[31:2], 2'b00}), d);
            acked = 1;
            break;
         end else if (mem_req === 1'b1) begin
            chk(mem_we === 1'b1 && mem_burst === 1'b0, "R4", "store kind",
                {30'd0, mem_we, mem_burst}, 32'd2);
            chk(mem_addr === {a[31:2], 2'b00}, "R4", "store address", mem_addr,
                {a[31:2], 2'b00});
            chk(mem_wdata === d, "R4", "store data", mem_wdata, d);
         end
         @(negedge clk); #1;
      end
      if (!acked) chk(1'b0, rq, "store never acknowledged", 32'd0, 32'd1);
      if (hit) m_touch(int'(a[10:4]), way);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      cpu_we  = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk); #1;
      flush = 1'b1;
      #4;
      chk(cpu_ack === 1'b0 && mem_req === 1'b0, "R1", "flush cycle quiet",
          {30'd0, cpu_ack, mem_req}, 32'd0);
      @(posedge clk);
      m_flush();
      #1;
      flush = 1'b0;
   endtask

   function automatic logic [31:0] set5(input int k);
      return (32'(k) << 11) | (32'd5 << 4) | 32'd8;
   endfunction

   // watchdog
   initial begin
      #4000000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      int seed;
      rst_n     = 1'b0;
      flush     = 1'b0;
      cpu_req   = 1'b0;
      cpu_we    = 1'b0;
      cpu_addr  = '0;
      cpu_wdata = '0;
      m_flush();
      for (int s = 0; s < 128; s++) ml[s] = 3'b000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #5;
      // R1: reset state
      chk(cpu_ack === 1'b0 && mem_req === 1'b0, "R1", "reset outputs",
          {30'd0, cpu_ack, mem_req}, 32'd0);

      // R1 cold miss, R3 fill, R7 way 0, then R2 hits and R10 word select
      do_rd(32'h0000_1040, 0, "R3");
      do_rd(32'h0000_1040, 0, "R2");
      do_rd(32'h0000_1044, 0, "R2");
      do_rd(32'h0000_104F, 0, "R10");
      do_rd(32'h0000_1043, 0, "R10");
      lat = 2;
      do_rd(32'h0000_2250, 0, "R3");
      lat = 1;

      // R5 store hit then read hit of new value
      do_wr(32'h0000_1048, 32'hDEAD_BEEF, "R5");
      do_rd(32'h0000_1048, 0, "R5");
      // R6 store miss allocates nothing
      do_wr(32'h0007_7730, 32'h1234_5678, "R6");
      do_rd(32'h0007_7730, 0, "R6");

      // R7 fill free ways, R8 victim tree, R9 touch updates
      lat = 0;
      for (int k = 1; k <= 4; k++) do_rd(set5(k), 0, "R7");
      do_rd(set5(1), 0, "R9");
      do_rd(set5(3), 0, "R9");
      do_rd(set5(5), 0, "R8");
      for (int k = 1; k <= 5; k++) do_rd(set5(k), 0, "R8");
      // R10 tag top bit distinguishes lines
      do_rd(set5(2) | 32'h8000_0000, 0, "R10");
      do_rd(set5(2), 0, "R10");
      seed = 32'h1ACE;
      for (int i = 0; i < 30; i++) begin
         seed = seed * 1103515245 + 12345;
         do_rd(set5(((seed >>> 8) & 32'h7fff) % 7 + 1), 0, "R8");
      end

      // R1 flush
      do_flush();
      do_rd(32'h0000_1040, 0, "R1");
      do_rd(32'h0000_1040, 1, "R1");

      // mixed traffic
      for (int i = 0; i < 80; i++) begin
         logic [31:0] a;
         int r;
         seed = seed * 1103515245 + 12345;
         r = (seed >>> 8) & 32'h7fff;
         lat = r % 3;
         a = (32'(r % 6 + 1) << 11) | (32'((r / 6) % 3 * 4 + 3) << 4) | (32'((r / 18) % 4) << 2);
         if ((r / 72) % 4 == 0) do_wr(a, 32'(seed) ^ 32'h5A5A_0000, "R4");
         else                   do_rd(a, 0, "R9");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule